// File: doc/BRIEF.md
# Non-Volatile Byte Store Access Controller

This block connects the register bus of a small processor to a byte-wide non-volatile data store, held inside the design as a plain register array. The processor sees three registers: an address, a data byte and a control byte. The control byte carries a read strobe and a write-start bit. The write-start bit also reads back as the busy flag. A read copies the addressed byte into the data register at once. It then holds the processor stall output high for a fixed four clock cycles.

A write latches the address and data at the moment it starts. Its length is counted in ticks of a separate calibrated oscillator, not in processor clock cycles. While a write is pending, address changes and read strobes are refused. The processor reset does not stop a pending write, which still lands in the array. A low supply-good input acts as a brown-out. It resets everything, drops any pending write and prevents a new one from starting. A one-cycle completion pulse marks the end of each write.

Top module: `nvm_access_ctrl`

## Requirements
- R1: The bus select picks a register: 0 is the address (low ADDR_W bits), 1 is the data byte, 2 is control, and 3 reads as zero. In control, bit 0 is the read strobe and always reads back 0. Bit 1 starts a write and reads back as the busy flag. After reset, address, data and control all read 0.
- R2: A control write with bit 0 set while idle (not busy, not stalled) loads the data register with the array byte at the current address on that clock edge.
- R3: An accepted read holds the stall output high for exactly four cycles, starting the cycle after the strobe. A read strobe issued while the stall is high is ignored.
- R4: While busy reads 1, a read strobe has no effect and a write to the address register is discarded. Writes to the data register are still accepted.
- R5: A control write with bit 1 set while idle captures the current address and data, and busy reads 1 from the next cycle. Later changes to the data register do not alter the byte that is stored.
- R6: Busy stays set until WR_TICKS oscillator ticks have been seen after the start. Clock cycles without a tick do not advance the count. The array byte is updated on the edge where busy clears.
- R7: The write-done output is high for exactly one cycle, in the first cycle in which busy reads 0 after a write.
- R8: Reset clears address, data and stall and ignores bus writes. A write that is already pending keeps busy set and still commits its byte.
- R9: While supply-good is low, the block is reset, any pending write is dropped without changing the array or pulsing done, and no write can start.
- R10: A control write with both bits 0 and 1 set while idle starts a write and performs no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high processor reset |
| supply_ok | input | 1 | High while the supply is adequate; low forces brown-out reset |
| osc_tick | input | 1 | One-cycle tick from the calibrated oscillator, synchronous to clk |
| bus_sel | input | 2 | Register select |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read-back of the selected register |
| cpu_stall | output | 1 | Holds the processor after a read |
| wr_done | output | 1 | One-cycle pulse when a write commits |

## Verification
The bench builds the block with a 4-bit address and WR_TICKS of 5, and issues an oscillator tick every third clock. Each write therefore takes about fifteen clock cycles. That is long enough to insert refused address writes, refused strobes, data changes, a processor reset and a brown-out inside a single write. The idle cycles between ticks also show that the count does not advance on plain clock cycles.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_RD_BIT  = 0;
    localparam int CTRL_WR_BIT  = 1;
    localparam int STALL_CYCLES = 4;
    localparam int MAX_ADDR_W   = 16;
    localparam int STALL_W      = $clog2(STALL_CYCLES + 1);

    typedef struct packed {
        logic                  valid;
        logic [MAX_ADDR_W-1:0] addr;
        logic [7:0]            data;
    } wr_job_t;

    function automatic logic [7:0] ctrl_view(input logic busy);
        logic [7:0] v;
        v = 8'h00;
        v[CTRL_WR_BIT] = busy;
        return v;
    endfunction

endpackage

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int ADDR_W = 6
) (
    input  logic                  clk,
    input  nvm_pkg::wr_job_t      wr_i,
    input  logic [ADDR_W-1:0]     raddr_i,
    output logic [7:0]            rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_i.valid) begin
            cells[wr_i.addr[ADDR_W-1:0]] <= wr_i.data;
        end
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/nvm_write_engine.sv
module nvm_write_engine #(
    parameter int ADDR_W   = 6,
    parameter int WR_TICKS = 3400
) (
    input  logic             clk,
    input  logic             supply_ok,
    input  logic             osc_tick,
    input  nvm_pkg::wr_job_t start_i,
    output logic             busy_o,
    output nvm_pkg::wr_job_t commit_o,
    output logic             done_o
);
    localparam int CNT_W = $clog2(WR_TICKS + 1);

    logic [CNT_W-1:0] tick_cnt;
    nvm_pkg::wr_job_t job_q;
    logic             last_tick;

    assign last_tick = busy_o && osc_tick && (tick_cnt == CNT_W'(1));

    // Only brown-out resets this engine; the processor reset must not abort a write.
    always_ff @(posedge clk) begin
        if (!supply_ok) begin
            busy_o   <= 1'b0;
            tick_cnt <= '0;
            done_o   <= 1'b0;
            job_q    <= '0;
        end else begin
            done_o <= 1'b0;
            if (busy_o) begin
                if (osc_tick) begin
                    if (last_tick) begin
                        busy_o <= 1'b0;
                        done_o <= 1'b1;
                    end else begin
                        tick_cnt <= tick_cnt - CNT_W'(1);
                    end
                end
            end else if (start_i.valid) begin
                busy_o   <= 1'b1;
                tick_cnt <= CNT_W'(WR_TICKS);
                job_q    <= start_i;
            end
        end
    end

    always_comb begin
        commit_o       = job_q;
        commit_o.valid = last_tick && supply_ok;
    end

    assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!supply_ok)
        done_o |=> !done_o);

    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!supply_ok)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (!supply_ok)
        (busy_o && !osc_tick) |=> (busy_o && $stable(tick_cnt)));

    assert_brownout_drops_R9: assert property (@(posedge clk) disable iff (1'b0)
        !supply_ok |=> (!busy_o && !done_o));

endmodule

// File: rtl/nvm_regfile.sv
module nvm_regfile #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic [1:0]        bus_sel,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    input  logic              busy_i,
    input  logic [7:0]        mem_rdata_i,
    output logic [ADDR_W-1:0] mem_raddr_o,
    output nvm_pkg::wr_job_t  start_o,
    output logic [7:0]        rdata_o,
    output logic              stall_o
);
    import nvm_pkg::*;

    reg_sel_e            sel;
    logic                rst_any;
    logic [ADDR_W-1:0]   addr_q;
    logic [7:0]          data_q;
    logic [STALL_W-1:0]  stall_cnt;
    logic                ctrl_wr, want_rd, want_wr, read_fire, write_fire;

    assign sel        = reg_sel_e'(bus_sel);
    assign rst_any    = rst || !supply_ok;
    assign ctrl_wr    = bus_we && (sel == SEL_CTRL) && !rst_any;
    assign want_wr    = ctrl_wr && bus_wdata[CTRL_WR_BIT];
    assign want_rd    = ctrl_wr && bus_wdata[CTRL_RD_BIT] && !bus_wdata[CTRL_WR_BIT];
    assign write_fire = want_wr && !busy_i;
    assign read_fire  = want_rd && !busy_i && (stall_cnt == '0);
    assign stall_o    = (stall_cnt != '0);
    assign mem_raddr_o = addr_q;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            addr_q    <= '0;
            data_q    <= '0;
            stall_cnt <= '0;
        end else begin
            if (stall_cnt != '0) begin
                stall_cnt <= stall_cnt - STALL_W'(1);
            end
            if (bus_we && (sel == SEL_ADDR) && !busy_i) begin
                addr_q <= bus_wdata[ADDR_W-1:0];
            end
            if (bus_we && (sel == SEL_DATA)) begin
                data_q <= bus_wdata;
            end
            if (read_fire) begin
                data_q    <= mem_rdata_i;
                stall_cnt <= STALL_W'(STALL_CYCLES);
            end
        end
    end

    always_comb begin
        start_o       = '0;
        start_o.valid = write_fire;
        start_o.addr  = MAX_ADDR_W'(addr_q);
        start_o.data  = data_q;
    end

    always_comb begin
        unique case (sel)
            SEL_ADDR: rdata_o = 8'(addr_q);
            SEL_DATA: rdata_o = data_q;
            SEL_CTRL: rdata_o = ctrl_view(busy_i);
            default:  rdata_o = 8'h00;
        endcase
    end

    assert_addr_locked_R4: assert property (@(posedge clk) disable iff (rst_any)
        busy_i |=> $stable(addr_q));

    assert_read_loads_R2: assert property (@(posedge clk) disable iff (rst_any)
        read_fire |=> (data_q == $past(mem_rdata_i)));

    assert_stall_min_R3: assert property (@(posedge clk) disable iff (rst_any)
        $rose(stall_o) |=> stall_o ##1 stall_o ##1 stall_o);

    assert_stall_max_R3: assert property (@(posedge clk) disable iff (rst_any)
        (stall_o && $past(stall_o, 1) && $past(stall_o, 2) && $past(stall_o, 3)) |=> !stall_o);

endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl #(
    parameter int ADDR_W   = 6,
    parameter int WR_TICKS = 3400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       osc_tick,
    input  logic [1:0] bus_sel,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       cpu_stall,
    output logic       wr_done
);
    nvm_pkg::wr_job_t  start_job, commit_job;
    logic              busy;
    logic [ADDR_W-1:0] raddr;
    logic [7:0]        rbyte;

    initial begin
        if (ADDR_W > nvm_pkg::MAX_ADDR_W || ADDR_W < 1 || WR_TICKS < 1) begin
            $error("nvm_access_ctrl: parameter out of range");
        end
    end

    nvm_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .supply_ok   (supply_ok),
        .bus_sel     (bus_sel),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .busy_i      (busy),
        .mem_rdata_i (rbyte),
        .mem_raddr_o (raddr),
        .start_o     (start_job),
        .rdata_o     (bus_rdata),
        .stall_o     (cpu_stall)
    );

    nvm_write_engine #(.ADDR_W(ADDR_W), .WR_TICKS(WR_TICKS)) u_wr (
        .clk       (clk),
        .supply_ok (supply_ok),
        .osc_tick  (osc_tick),
        .start_i   (start_job),
        .busy_o    (busy),
        .commit_o  (commit_job),
        .done_o    (wr_done)
    );

    nvm_array #(.ADDR_W(ADDR_W)) u_cells (
        .clk     (clk),
        .wr_i    (commit_job),
        .raddr_i (raddr),
        .rdata_o (rbyte)
    );

endmodule

// File: tb/nvm_access_ctrl_test.sv
module nvm_access_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 4;
    localparam int WT  = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_ok = 1'b0;
    logic       osc_tick = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cpu_stall, wr_done;

    int checks = 0;
    int errors = 0;
    int done_count = 0;
    int edges = 0;

    nvm_access_ctrl #(.ADDR_W(AW), .WR_TICKS(WT)) uut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .osc_tick(osc_tick),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_stall(cpu_stall), .wr_done(wr_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    int   m_addr = 0, m_data = 0, m_stall = 0, m_busy = 0, m_cnt = 0, m_done = 0;
    int   m_waddr = 0, m_wdata = 0;
    int   m_mem [16];

    initial foreach (m_mem[i]) m_mem[i] = 0;

    always @(posedge clk) begin
        int  ob, os;
        bit  anyr;
        ob = m_busy; os = m_stall;
        anyr = rst || !supply_ok;
        edges++;
        if (!supply_ok) begin
            m_busy = 0; m_cnt = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (ob != 0) begin
                if (osc_tick) begin
                    if (m_cnt == 1) begin
                        m_mem[m_waddr] = m_wdata; m_busy = 0; m_done = 1;
                    end else m_cnt--;
                end
            end else if (!rst && bus_we && bus_sel == 2 && bus_wdata[1]) begin
                m_busy = 1; m_cnt = WT; m_waddr = m_addr; m_wdata = m_data;
            end
        end
        if (anyr) begin
            m_addr = 0; m_data = 0; m_stall = 0;
        end else begin
            if (m_stall > 0) m_stall--;
            if (bus_we && bus_sel == 0 && ob == 0) m_addr = bus_wdata % 16;
            if (bus_we && bus_sel == 1) m_data = bus_wdata;
            if (bus_we && bus_sel == 2 && !bus_wdata[1] && bus_wdata[0] && ob == 0 && os == 0) begin
                m_data = m_mem[m_addr]; m_stall = 4;
            end
        end
    end

    function automatic int model_rdata(input int s);
        case (s)
            0: return m_addr;
            1: return m_data;
            2: return m_busy * 2;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (wr_done) done_count++;
        if (edges >= 2) begin
            chk(cpu_stall == (m_stall != 0), "R3 stall vs model", cpu_stall, m_stall != 0);
            chk(wr_done == m_done[0], "R7 done vs model", wr_done, m_done);
            chk(int'(bus_rdata) == model_rdata(bus_sel), "R1 readback vs model",
                bus_rdata, model_rdata(bus_sel));
        end
    end

    // Oscillator tick: one every third clock
    initial begin
        forever begin
            repeat (2) @(negedge clk);
            #1 osc_tick = 1'b1;
            @(negedge clk);
            #1 osc_tick = 1'b0;
        end
    end

    task automatic bus_write(input int s, input int v);
        @(negedge clk); #1;
        bus_sel = 2'(s); bus_wdata = 8'(v); bus_we = 1'b1;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic read_reg(input int s, output int v);
        @(negedge clk); #1;
        bus_sel = 2'(s);
        #1 v = bus_rdata;
    endtask

    task automatic wait_idle();
        int v;
        for (int i = 0; i < 300; i++) begin
            read_reg(2, v);
            if (v[1] == 1'b0) break;
        end
    endtask

    task automatic read_byte(input int a, output int v);
        bus_write(0, a);
        bus_write(2, 1);
        repeat (5) @(negedge clk);
        read_reg(1, v);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, n, dc;
        repeat (2) @(negedge clk);
        #1 supply_ok = 1'b1;
        repeat (2) @(negedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        read_reg(0, v); chk(v == 0, "R1 addr after reset", v, 0);
        read_reg(1, v); chk(v == 0, "R1 data after reset", v, 0);
        read_reg(2, v); chk(v == 0, "R1 ctrl after reset", v, 0);
        read_reg(3, v); chk(v == 0, "R1 select 3 reads zero", v, 0);

        // R5 write start, R4 lockout
        dc = done_count;
        bus_write(0, 5); bus_write(1, 8'hA5); bus_write(2, 2);
        read_reg(2, v); chk(v == 2, "R5 busy set after start", v, 2);
        bus_write(1, 8'h11);
        bus_write(0, 9);
        read_reg(0, v); chk(v == 5, "R4 address write discarded", v, 5);
        bus_write(2, 1);
        chk(cpu_stall == 1'b0, "R4 strobe while busy gives no stall", cpu_stall, 0);
        read_reg(1, v); chk(v == 8'h11, "R4 strobe while busy leaves data", v, 8'h11);
        wait_idle();
        chk(done_count == dc + 1, "R7 one done pulse per write", done_count, dc + 1);

        // R2/R3 read and stall length
        bus_write(0, 5);
        bus_write(2, 1);
        n = 0;
        while (cpu_stall && n < 10) begin n++; @(negedge clk); #1; end
        chk(n == 4, "R3 stall lasts four cycles", n, 4);
        read_reg(1, v); chk(v == 8'hA5, "R2 R5 stored byte is captured value", v, 8'hA5);

        // R3 strobe during stall ignored
        bus_write(0, 6); bus_write(1, 8'h42); bus_write(2, 2); wait_idle();
        bus_write(0, 5);
        bus_write(2, 1);
        bus_write(0, 6);
        bus_write(2, 1);
        repeat (5) @(negedge clk);
        read_reg(1, v); chk(v == 8'hA5, "R3 strobe during stall ignored", v, 8'hA5);
        read_byte(6, v); chk(v == 8'h42, "R2 read of second location", v, 8'h42);

        // R10 both bits: write wins, no read
        bus_write(0, 5); bus_write(1, 8'h3C); bus_write(2, 3);
        chk(cpu_stall == 1'b0, "R10 no stall when both bits set", cpu_stall, 0);
        read_reg(1, v); chk(v == 8'h3C, "R10 no read performed", v, 8'h3C);
        read_reg(2, v); chk(v == 2, "R10 write started", v, 2);
        wait_idle();
        read_byte(5, v); chk(v == 8'h3C, "R10 write committed", v, 8'h3C);

        // R8 reset during write
        dc = done_count;
        bus_write(0, 2); bus_write(1, 8'h77); bus_write(2, 2);
        @(negedge clk); #1 rst = 1'b1; bus_sel = 2'd0; bus_wdata = 8'h0F; bus_we = 1'b1;
        repeat (2) @(negedge clk);
        #1 rst = 1'b0; bus_we = 1'b0;
        read_reg(0, v); chk(v == 0, "R8 address cleared by reset", v, 0);
        read_reg(1, v); chk(v == 0, "R8 data cleared by reset", v, 0);
        read_reg(2, v); chk(v == 2, "R8 write still busy across reset", v, 2);
        wait_idle();
        chk(done_count == dc + 1, "R8 pending write completes", done_count, dc + 1);
        read_byte(2, v); chk(v == 8'h77, "R8 byte committed after reset", v, 8'h77);

        // R9 brown-out aborts
        bus_write(0, 3); bus_write(1, 8'h55); bus_write(2, 2); wait_idle();
        dc = done_count;
        bus_write(1, 8'h99); bus_write(2, 2);
        repeat (2) @(negedge clk);
        #1 supply_ok = 1'b0; bus_sel = 2'd2; bus_wdata = 8'h02; bus_we = 1'b1;
        @(negedge clk);
        #1 supply_ok = 1'b1; bus_we = 1'b0;
        read_reg(2, v); chk(v == 0, "R9 write dropped by brown-out", v, 0);
        read_reg(0, v); chk(v == 0, "R9 address reset by brown-out", v, 0);
        repeat (30) @(negedge clk);
        chk(done_count == dc, "R9 no done after abort", done_count, dc);
        read_byte(3, v); chk(v == 8'h55, "R9 array unchanged by aborted write", v, 8'h55);

        // R6 duration in ticks: count busy cycles with ticks
        bus_write(0, 7); bus_write(1, 8'hC3); bus_write(2, 2);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            read_reg(2, v);
            if (v[1] == 1'b0) break;
            n++;
        end
        chk(n >= 3 * (WT - 1) && n <= 3 * WT + 1, "R6 busy spans WR_TICKS ticks", n, 3 * WT);
        read_byte(7, v); chk(v == 8'hC3, "R6 byte stored at end of write", v, 8'hC3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule